// File: doc/BRIEF.md
# Page-Mode Dynamic Memory Access Sequencer

This block sits between a memory arbiter and a small dynamic storage array. It turns each granted read or write into the steps such an array needs. First comes a slow row step: the row half of the address is driven on a shared address bus and the whole row is copied into a row buffer. Then come one or more fast column steps: the column half of the address is driven on the same bus, and one element of the buffer is read or replaced.

Reading a row out of the array empties it. The sequencer therefore keeps the row open in its buffer and writes the buffer back before it opens any other row. A later access to the open row is a page hit and skips the row step entirely.

A burst read supplies only its first column. The sequencer then steps through the following columns itself, wrapping inside the row. A refresh grant closes the open row with a write-back, then opens the refresh row and writes it back, and leaves no row open.

Top module: `pms_seq`

## Requirements
- R1: `acc_gnt` rises only while the sequencer is idle, `acc_req` is high and `rfsh_gnt` is low. When both grants arrive together, `rfsh_ack` is given and the access waits.
- R2: An access with no open row begins with `ROW_CYC` cycles of `row_stb`, with `mem_addr` carrying the row field. The row field is the upper `ROW_W` bits of `acc_addr`.
- R3: Each column step drives `col_stb` for `COL_CYC` cycles, with `mem_addr` carrying the column field (the lower `COL_W` bits of `acc_addr`). `row_stb` and `col_stb` are never high together.
- R4: `rd_valid` is high for exactly one cycle per delivered element. That cycle is the one right after the element's last column cycle, and `rd_data` then holds the element.
- R5: A write replaces the addressed element. A later read of that element returns the written value.
- R6: An access to the row that is already open produces no `row_stb` cycles. Its column steps start in the cycle after the grant.
- R7: An access to a different row first writes back the open row for `ROW_CYC` cycles of `row_stb`, with `mem_addr` holding the old row. Only then does the new row open. Data in the old row survives the change.
- R8: A read with `acc_burst` high delivers `BURST_LEN` elements from consecutive columns, counting up from the given column and wrapping from the last column of the row to column 0.
- R9: `acc_burst` has no effect on a write: exactly one column step happens and only the addressed element changes.
- R10: A refresh takes three steps. It first writes back any open row (`ROW_CYC` cycles). It then opens `rfsh_row` (`ROW_CYC` cycles) and writes it back (`ROW_CYC` cycles). It ends idle with no row open, keeping the data of every row.
- R11: After reset both strobes, `rd_valid` and `mem_addr` are low, and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_req | input | 1 | Access request from the arbiter |
| acc_addr | input | ROW_W+COL_W | Access address: row field in the upper bits, column in the lower bits |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_burst | input | 1 | Burst read request |
| acc_wdata | input | DATA_W | Write data |
| acc_gnt | output | 1 | Access accepted this cycle |
| rfsh_gnt | input | 1 | Refresh grant from the arbiter |
| rfsh_row | input | ROW_W | Row to refresh |
| rfsh_ack | output | 1 | Refresh accepted this cycle |
| row_stb | output | 1 | Row step in progress (open or write-back) |
| col_stb | output | 1 | Column step in progress |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row or column address |
| rd_data | output | DATA_W | Read element |
| rd_valid | output | 1 | One-cycle pulse per delivered element |

## Verification
Several rules are checked by the bound checker on every cycle. The two strobes are never high together, and grants occur only while no strobe is active. The refresh grant wins over an access. Every grant is followed by a strobe in the next cycle. Every read pulse follows a column cycle. Page hit versus row change, write-back addressing, burst wrap, a burst write held to one column, and data surviving destructive reads and refreshes need the bench's reference model. That model predicts every strobe, bus value and read element cycle by cycle.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_COL,
        ST_WB
    } seq_st_e;

    typedef enum logic [0:0] {
        NX_IDLE,
        NX_OPEN
    } after_wb_e;

endpackage

// File: rtl/pms_array.sv
module pms_array #(
    parameter int ROW_W  = 3,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int ROWS = 1 << ROW_W;

    logic [LINE_W-1:0] cells_q [ROWS];

    assign rd_line = cells_q[rd_row];

    // reading a row drains it; only a write-back restores it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) cells_q[i] <= '0;
        end else begin
            if (rd_en) cells_q[rd_row] <= '0;
            if (wr_en) cells_q[wr_row] <= wr_line;
        end
    end
endmodule

// File: rtl/pms_rowbuf.sv
module pms_rowbuf #(
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en,
    input  logic [(1<<COL_W)*DATA_W-1:0]  load_line,
    input  logic                          wr_en,
    input  logic [COL_W-1:0]              col,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DATA_W-1:0]             rd_elem,
    output logic [(1<<COL_W)*DATA_W-1:0]  line
);
    localparam int COLS = 1 << COL_W;

    logic [(1<<COL_W)*DATA_W-1:0] line_q;
    logic [DATA_W-1:0]            elem [COLS];

    for (genvar g = 0; g < COLS; g++) begin : g_elem
        assign elem[g] = line_q[g*DATA_W +: DATA_W];
    end

    assign rd_elem = elem[col];
    assign line    = line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (load_en) begin
            line_q <= load_line;
        end else if (wr_en) begin
            for (int c = 0; c < COLS; c++) begin
                if (col == COL_W'(c)) line_q[c*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/pms_seq.sv
module pms_seq
    import pms_pkg::*;
#(
    parameter int ROW_W     = 3,
    parameter int COL_W     = 3,
    parameter int DATA_W    = 8,
    parameter int ROW_CYC   = 16,
    parameter int COL_CYC   = 2,
    parameter int BURST_LEN = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   acc_req,
    input  logic [ROW_W+COL_W-1:0]                 acc_addr,
    input  logic                                   acc_wr,
    input  logic                                   acc_burst,
    input  logic [DATA_W-1:0]                      acc_wdata,
    output logic                                   acc_gnt,
    input  logic                                   rfsh_gnt,
    input  logic [ROW_W-1:0]                       rfsh_row,
    output logic                                   rfsh_ack,
    output logic                                   row_stb,
    output logic                                   col_stb,
    output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]   mem_addr,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   rd_valid
);
    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int MUX_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int LINE_W  = (1 << COL_W) * DATA_W;
    localparam int MAX_CYC = (ROW_CYC > COL_CYC) ? ROW_CYC : COL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int BL_W    = $clog2(BURST_LEN + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [BL_W-1:0]   left;
        logic              open_v;
        logic [ROW_W-1:0]  open_row;
        after_wb_e         nx;
        logic              is_rf;
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } seq_s;

    seq_s s_d, s_q;

    logic              arr_rd, arr_wr, buf_load, buf_wr;
    logic [LINE_W-1:0] arr_line, buf_line;
    logic [DATA_W-1:0] buf_elem;
    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;

    assign req_row = acc_addr[ADDR_W-1:COL_W];
    assign req_col = acc_addr[COL_W-1:0];

    pms_array #(.ROW_W(ROW_W), .LINE_W(LINE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (arr_rd),
        .rd_row  (s_q.row),
        .rd_line (arr_line),
        .wr_en   (arr_wr),
        .wr_row  (s_q.open_row),
        .wr_line (buf_line)
    );

    pms_rowbuf #(.COL_W(COL_W), .DATA_W(DATA_W)) u_rowbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (buf_load),
        .load_line (arr_line),
        .wr_en     (buf_wr),
        .col       (s_q.col),
        .wr_data   (s_q.wdata),
        .rd_elem   (buf_elem),
        .line      (buf_line)
    );

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        acc_gnt      = 1'b0;
        rfsh_ack     = 1'b0;
        arr_rd       = 1'b0;
        arr_wr       = 1'b0;
        buf_load     = 1'b0;
        buf_wr       = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (rfsh_gnt) begin
                    rfsh_ack  = 1'b1;
                    s_d.row   = rfsh_row;
                    s_d.is_rf = 1'b1;
                    s_d.cnt   = CNT_W'(ROW_CYC - 1);
                    s_d.nx    = NX_OPEN;
                    s_d.st    = s_q.open_v ? ST_WB : ST_OPEN;
                end else if (acc_req) begin
                    acc_gnt   = 1'b1;
                    s_d.row   = req_row;
                    s_d.col   = req_col;
                    s_d.wr    = acc_wr;
                    s_d.wdata = acc_wdata;
                    s_d.is_rf = 1'b0;
                    s_d.nx    = NX_OPEN;
                    s_d.left  = (acc_burst && !acc_wr) ? BL_W'(BURST_LEN - 1) : '0;
                    if (s_q.open_v && s_q.open_row == req_row) begin
                        s_d.st  = ST_COL;
                        s_d.cnt = CNT_W'(COL_CYC - 1);
                    end else begin
                        s_d.st  = s_q.open_v ? ST_WB : ST_OPEN;
                        s_d.cnt = CNT_W'(ROW_CYC - 1);
                    end
                end
            end
            ST_OPEN: begin
                if (s_q.cnt == '0) begin
                    arr_rd       = 1'b1;
                    buf_load     = 1'b1;
                    s_d.open_v   = 1'b1;
                    s_d.open_row = s_q.row;
                    if (s_q.is_rf) begin
                        s_d.st  = ST_WB;
                        s_d.nx  = NX_IDLE;
                        s_d.cnt = CNT_W'(ROW_CYC - 1);
                    end else begin
                        s_d.st  = ST_COL;
                        s_d.cnt = CNT_W'(COL_CYC - 1);
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (s_q.cnt == '0) begin
                    if (s_q.wr) begin
                        buf_wr = 1'b1;
                    end else begin
                        s_d.rd_data  = buf_elem;
                        s_d.rd_valid = 1'b1;
                    end
                    if (s_q.left != '0) begin
                        s_d.left = s_q.left - 1'b1;
                        s_d.col  = s_q.col + 1'b1;
                        s_d.cnt  = CNT_W'(COL_CYC - 1);
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_WB: begin
                if (s_q.cnt == '0) begin
                    arr_wr     = 1'b1;
                    s_d.open_v = 1'b0;
                    if (s_q.nx == NX_OPEN) begin
                        s_d.st  = ST_OPEN;
                        s_d.cnt = CNT_W'(ROW_CYC - 1);
                    end else begin
                        s_d.st = ST_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
            s_q.nx <= NX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        row_stb  = (s_q.st == ST_OPEN) || (s_q.st == ST_WB);
        col_stb  = (s_q.st == ST_COL);
        mem_addr = '0;
        if (s_q.st == ST_OPEN) mem_addr = MUX_W'(s_q.row);
        if (s_q.st == ST_WB)   mem_addr = MUX_W'(s_q.open_row);
        if (s_q.st == ST_COL)  mem_addr = MUX_W'(s_q.col);
    end

    assign rd_data  = s_q.rd_data;
    assign rd_valid = s_q.rd_valid;
endmodule

// File: rtl/pms_seq_chk.sv
module pms_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_req,
    input logic acc_gnt,
    input logic rfsh_gnt,
    input logic rfsh_ack,
    input logic row_stb,
    input logic col_stb,
    input logic rd_valid
);
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_stb && col_stb));

    assert_gnt_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> (acc_req && !rfsh_gnt && !row_stb && !col_stb));

    assert_gnt_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |=> (row_stb || col_stb));

    assert_rfsh_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_ack |-> (rfsh_gnt && !acc_gnt && !row_stb && !col_stb));

    assert_rfsh_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_ack |=> (row_stb && !col_stb));

    assert_valid_after_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(col_stb));
endmodule

bind pms_seq pms_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_req  (acc_req),
    .acc_gnt  (acc_gnt),
    .rfsh_gnt (rfsh_gnt),
    .rfsh_ack (rfsh_ack),
    .row_stb  (row_stb),
    .col_stb  (col_stb),
    .rd_valid (rd_valid)
);

// File: tb/pms_seq_tb.sv
module pms_seq_tb;
    localparam int RW = 3, CW = 3, DW = 8, RC = 16, CC = 2, BL = 4;
    localparam int COLS = 1 << CW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_req = 1'b0, acc_wr = 1'b0, acc_burst = 1'b0, rfsh_gnt = 1'b0;
    logic [RW+CW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic [RW-1:0] rfsh_row = '0;
    logic acc_gnt, rfsh_ack, row_stb, col_stb, rd_valid;
    logic [2:0] mem_addr;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;

    pms_seq #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .ROW_CYC(RC),
              .COL_CYC(CC), .BURST_LEN(BL)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
        .acc_wr(acc_wr), .acc_burst(acc_burst), .acc_wdata(acc_wdata),
        .acc_gnt(acc_gnt), .rfsh_gnt(rfsh_gnt), .rfsh_row(rfsh_row),
        .rfsh_ack(rfsh_ack), .row_stb(row_stb), .col_stb(col_stb),
        .mem_addr(mem_addr), .rd_data(rd_data), .rd_valid(rd_valid));

    typedef struct {
        logic       rs;
        logic       cs;
        logic [2:0] ad;
        logic       rv;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    logic [7:0] mdl [8][8];
    int  m_open = -1;
    logic pend = 1'b0;
    logic [7:0] pend_d = '0;
    logic mon_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic push(input logic rs, input logic cs, input int ad, input string tag);
        exp_t e;
        e.rs = rs; e.cs = cs; e.ad = 3'(ad); e.rv = pend; e.rd = pend_d; e.tag = tag;
        pend = 1'b0;
        exp_q.push_back(e);
    endtask

    task automatic plan_acc(input int row, input int col, input bit wr, input bit burst,
                            input logic [7:0] wd);
        int n;
        string ctag;
        ctag = (m_open == row) ? "R6" : "R3";
        if (m_open != row) begin
            if (m_open >= 0) repeat (RC) push(1, 0, m_open, "R7");
            repeat (RC) push(1, 0, row, "R2");
            m_open = row;
        end
        n = (burst && !wr) ? BL : 1;        // R9: burst ignored on writes
        if (burst) ctag = wr ? "R9" : "R8";
        for (int k = 0; k < n; k++) begin
            int c;
            c = (col + k) % COLS;
            repeat (CC) push(0, 1, c, ctag);
            if (wr) mdl[row][c] = wd;
            else begin pend = 1'b1; pend_d = mdl[row][c]; end
        end
        if (pend) push(0, 0, 0, "R4");
    endtask

    task automatic plan_rf(input int row);
        if (m_open >= 0) repeat (RC) push(1, 0, m_open, "R10");
        repeat (RC) push(1, 0, row, "R10");
        repeat (RC) push(1, 0, row, "R10");
        m_open = -1;
    endtask

    // cycle-by-cycle comparison against the reference model
    always @(negedge clk) begin
        if (mon_on) begin
            exp_t e;
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else begin e.rs = 0; e.cs = 0; e.ad = 0; e.rv = 0; e.rd = 0; e.tag = "R1"; end
            chk(row_stb == e.rs, e.tag, "row_stb", int'(row_stb), int'(e.rs));
            chk(col_stb == e.cs, e.tag, "col_stb", int'(col_stb), int'(e.cs));
            chk(mem_addr == e.ad, e.tag, "mem_addr", int'(mem_addr), int'(e.ad));
            chk(rd_valid == e.rv, "R4", "rd_valid", int'(rd_valid), int'(e.rv));
            if (e.rv) chk(rd_data == e.rd, "R5", "rd_data", int'(rd_data), int'(e.rd));
            if (acc_gnt)
                plan_acc(int'(acc_addr[5:3]), int'(acc_addr[2:0]), acc_wr, acc_burst, acc_wdata);
            if (rfsh_ack) plan_rf(int'(rfsh_row));
        end
    end

    task automatic acc(input int row, input int col, input bit wr, input bit burst,
                       input logic [7:0] wd);
        @(posedge clk); #1;
        acc_req = 1'b1; acc_addr = 6'((row << 3) | col);
        acc_wr = wr; acc_burst = burst; acc_wdata = wd;
        @(negedge clk);
        while (!acc_gnt) @(negedge clk);
        @(posedge clk); #1;
        acc_req = 1'b0;
    endtask

    task automatic rfsh(input int row);
        @(posedge clk); #1;
        rfsh_gnt = 1'b1; rfsh_row = 3'(row);
        @(negedge clk);
        while (!rfsh_ack) @(negedge clk);
        @(posedge clk); #1;
        rfsh_gnt = 1'b0;
    endtask

    task automatic drain;
        while (exp_q.size() > 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) mdl[r][c] = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!row_stb && !col_stb, "R11", "strobes", int'({row_stb, col_stb}), 0);
        chk(!rd_valid && mem_addr == 0, "R11", "rd_valid/addr", int'({rd_valid, mem_addr}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        mon_on = 1'b1;

        acc(2, 1, 1, 0, 8'hA5);      // R2 miss, R5 write
        acc(2, 1, 0, 0, 8'h00);      // R6 hit read
        acc(2, 7, 1, 0, 8'h77);
        acc(2, 0, 1, 0, 8'h10);
        acc(2, 6, 1, 0, 8'h66);
        drain();
        acc(2, 6, 0, 1, 8'h00);      // R8 burst 6,7,0,1 wrapping
        acc(5, 3, 1, 0, 8'h53);      // R7 row change
        acc(2, 7, 0, 0, 8'h00);      // R7 old row survived
        acc(2, 2, 1, 1, 8'h22);      // R9 burst write single
        acc(2, 3, 0, 0, 8'h00);      // R9 neighbour unchanged
        drain();
        rfsh(5);                      // R10 refresh with row 2 open
        acc(5, 3, 0, 0, 8'h00);      // R10 row 5 intact, miss
        drain();
        // R1: refresh wins over simultaneous access
        @(posedge clk); #1;
        acc_req = 1'b1; acc_addr = 6'((5 << 3) | 3); acc_wr = 1'b0; acc_burst = 1'b0;
        rfsh_gnt = 1'b1; rfsh_row = 3'd1;
        @(negedge clk);
        chk(rfsh_ack && !acc_gnt, "R1", "refresh priority", int'({rfsh_ack, acc_gnt}), 2);
        @(posedge clk); #1 rfsh_gnt = 1'b0;
        @(negedge clk);
        while (!acc_gnt) @(negedge clk);
        @(posedge clk); #1 acc_req = 1'b0;
        drain();
        acc(1, 0, 0, 1, 8'h00);      // R8 burst from column 0
        acc(2, 2, 0, 1, 8'h00);      // R8 burst over written data
        drain();

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule